// File: doc/BRIEF.md
# Host-to-SPI Flash Address Window Bridge

This block sits between a host bus front end and a serial flash engine. It takes each host memory request, with its 32-bit address, byte width, read/write flag and a flag naming the host cycle type, and checks the address against one programmable window. A request that hits the window and has a legal width is turned into a flash command descriptor. The descriptor holds the instruction opcode, a 24-bit flash address, a byte count, a dummy-byte flag and the write data. It is offered to the downstream engine.

The window start is the 16-bit base value placed in the upper half of the host address. The window size comes from a 3-bit code: a 1 MB window that doubles with each code step and saturates at 16 MB. The flash address is the host address minus the window start. While the engine works, the block holds the host in a long-wait state. It acknowledges for one cycle once the engine reports completion. A request that misses the window, or asks for a width its cycle type does not allow, is dropped: no command, no wait and no acknowledge.

Top module: `flash_win_bridge`

## Requirements
- R1: While rst_ni is low and in the first cycle after it rises, host_wait_o, host_ack_o and cmd_valid_o are all 0.
- R2: The window starts at {cfg_base_i, 16'h0000} and spans 2^(20+c) bytes, where c is cfg_size_i; every code above 4 gives the same 16 MB window as code 4.
- R3: A hit requires start <= address < start + span, with the end computed in 33 bits, so a window that reaches past FFFF_FFFF never matches low addresses.
- R4: cmd_addr_o equals the host address minus the window start, truncated to 24 bits.
- R5: A miss produces no cmd_valid_o, no host_wait_o and no host_ack_o.
- R6: req_size_i encodes the width (0 = 1 byte, 1 = 2 bytes, 2 = 4 bytes, 3 = illegal). With req_fwh_i = 0 (LPC memory cycle) only width 0 is legal. With req_fwh_i = 1 (firmware memory cycle) widths 0, 1 and 2 are legal. An illegal width is handled as a miss.
- R7: A read issues opcode 03h with cmd_dummy_o = 0 when cfg_rd_fast_i = 0, and opcode 0Bh with cmd_dummy_o = 1 when cfg_rd_fast_i = 1.
- R8: A write issues opcode ADh when cfg_wr_mode_i = 2 (address-increment program) and 02h for modes 0 (byte), 1 (page) and 3; cmd_dummy_o is 0 and cmd_wdata_o carries req_wdata_i.
- R9: cmd_valid_o rises in the cycle after an accepted request is sampled. It stays high, with every descriptor field stable, until a clock edge at which cmd_ready_i is 1.
- R10: host_wait_o is high from the cycle after acceptance until eng_done_i is sampled. In the next cycle host_ack_o is high for exactly one cycle, host_wait_o is low and host_rdata_o equals the eng_rdata_i sampled with eng_done_i.
- R11: A request presented while a previous one is still in flight (wait or ack phase) is ignored.
- R12: cmd_count_o equals 2^req_size_i (1, 2 or 4).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_base_i | input | 16 | Upper 16 bits of window start |
| cfg_size_i | input | 3 | Window size code |
| cfg_rd_fast_i | input | 1 | Select fast read with dummy byte |
| cfg_wr_mode_i | input | 2 | Program style: 0 byte, 1 page, 2 address-increment |
| req_valid_i | input | 1 | Host request strobe, one cycle |
| req_addr_i | input | 32 | Host address |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_fwh_i | input | 1 | 1 = firmware memory cycle, 0 = LPC memory cycle |
| req_size_i | input | 2 | Width code |
| req_wdata_i | input | 32 | Write data |
| host_wait_o | output | 1 | Long-wait indication to the host |
| host_ack_o | output | 1 | One-cycle completion acknowledge |
| host_rdata_o | output | 32 | Read data, valid with host_ack_o |
| cmd_valid_o | output | 1 | Descriptor offered to the engine |
| cmd_ready_i | input | 1 | Engine takes the descriptor |
| cmd_opcode_o | output | 8 | Flash instruction |
| cmd_addr_o | output | 24 | Flash address |
| cmd_count_o | output | 3 | Byte count |
| cmd_dummy_o | output | 1 | One dummy byte follows the address |
| cmd_wdata_o | output | 32 | Write data |
| eng_done_i | input | 1 | Engine finished the access |
| eng_rdata_i | input | 32 | Engine read data |

## Verification
An accepted request becomes visible one edge after it is sampled: cmd_valid_o, the descriptor and host_wait_o all show up together. The bench therefore checks them at the falling edge that follows the sampling edge. The acknowledge comes one edge after eng_done_i is sampled and falls one edge later, so the bench checks it at the next falling edge and again one cycle on. For misses, stalls and requests made while busy, the bench watches the outputs for several falling edges in a row, so that any late or stray response would be seen. Every input is driven on falling edges, away from the edge where the design samples.

// File: rtl/flash_win_pkg.sv
package flash_win_pkg;
  parameter int HADDR_W = 32;
  parameter int FADDR_W = 24;
  parameter int BASE_W  = 16;
  parameter int DATA_W  = 32;
  parameter int SZC_W   = 3;
  localparam int LOW_W  = HADDR_W - BASE_W;

  localparam logic [7:0] OP_READ  = 8'h03;
  localparam logic [7:0] OP_FREAD = 8'h0B;
  localparam logic [7:0] OP_PROG  = 8'h02;
  localparam logic [7:0] OP_AAI   = 8'hAD;

  typedef enum logic [1:0] {ST_IDLE, ST_ISSUE, ST_WAIT, ST_RESP} br_state_e;

  typedef struct packed {
    logic [7:0]         opcode;
    logic [FADDR_W-1:0] addr;
    logic [2:0]         count;
    logic               dummy;
    logic [DATA_W-1:0]  wdata;
  } cmd_desc_t;
endpackage

// File: rtl/flash_win_decode.sv
module flash_win_decode
  import flash_win_pkg::*;
#(
  parameter int MIN_WIN_LOG2 = 20
) (
  input  logic [BASE_W-1:0]  base_i,
  input  logic [SZC_W-1:0]   size_i,
  input  logic [HADDR_W-1:0] addr_i,
  output logic               hit_o,
  output logic [FADDR_W-1:0] faddr_o
);
  localparam int MAX_CODE = FADDR_W - MIN_WIN_LOG2;

  logic [SZC_W-1:0] code_c;
  logic [HADDR_W:0] start_w, span_w, end_w, addr_w;

  always_comb begin
    code_c  = (int'(size_i) > MAX_CODE) ? SZC_W'(MAX_CODE) : size_i;
    start_w = {1'b0, base_i, LOW_W'(0)};
    span_w  = (HADDR_W+1)'(1) << (MIN_WIN_LOG2 + int'(code_c));
    end_w   = start_w + span_w;  // 33-bit end: no wrap at top of space
    addr_w  = {1'b0, addr_i};
    hit_o   = (addr_w >= start_w) && (addr_w < end_w);
    faddr_o = addr_i[FADDR_W-1:0] - {base_i[FADDR_W-LOW_W-1:0], LOW_W'(0)};
  end
endmodule

// File: rtl/flash_win_req_check.sv
module flash_win_req_check
  import flash_win_pkg::*;
(
  input  logic       write_i,
  input  logic       fwh_i,
  input  logic [1:0] size_i,
  input  logic       rd_fast_i,
  input  logic [1:0] wr_mode_i,
  output logic       legal_o,
  output logic [7:0] opcode_o,
  output logic       dummy_o,
  output logic [2:0] count_o
);
  always_comb begin
    legal_o = fwh_i ? (size_i != 2'd3) : (size_i == 2'd0);
    count_o = 3'd1 << size_i;
    dummy_o = 1'b0;
    if (write_i) begin
      opcode_o = (wr_mode_i == 2'd2) ? OP_AAI : OP_PROG;
    end else if (rd_fast_i) begin
      opcode_o = OP_FREAD;
      dummy_o  = 1'b1;
    end else begin
      opcode_o = OP_READ;
    end
  end
endmodule

// File: rtl/flash_win_ctrl.sv
module flash_win_ctrl
  import flash_win_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic              accept_i,
  input  cmd_desc_t         desc_i,
  input  logic              cmd_ready_i,
  input  logic              eng_done_i,
  input  logic [DATA_W-1:0] eng_rdata_i,
  output cmd_desc_t         desc_o,
  output logic              cmd_valid_o,
  output logic              host_wait_o,
  output logic              host_ack_o,
  output logic [DATA_W-1:0] host_rdata_o
);
  br_state_e st_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q         <= ST_IDLE;
      desc_o       <= '0;
      host_rdata_o <= '0;
    end else begin
      unique case (st_q)
        ST_IDLE: if (req_valid_i && accept_i) begin
          desc_o <= desc_i;
          st_q   <= ST_ISSUE;
        end
        ST_ISSUE: if (cmd_ready_i) st_q <= ST_WAIT;
        ST_WAIT: if (eng_done_i) begin
          host_rdata_o <= eng_rdata_i;
          st_q         <= ST_RESP;
        end
        ST_RESP: st_q <= ST_IDLE;
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign cmd_valid_o = (st_q == ST_ISSUE);
  assign host_wait_o = (st_q == ST_ISSUE) || (st_q == ST_WAIT);
  assign host_ack_o  = (st_q == ST_RESP);
endmodule

// File: rtl/flash_win_bridge.sv
module flash_win_bridge
  import flash_win_pkg::*;
#(
  parameter int MIN_WIN_LOG2 = 20
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [BASE_W-1:0]  cfg_base_i,
  input  logic [SZC_W-1:0]   cfg_size_i,
  input  logic               cfg_rd_fast_i,
  input  logic [1:0]         cfg_wr_mode_i,
  input  logic               req_valid_i,
  input  logic [HADDR_W-1:0] req_addr_i,
  input  logic               req_write_i,
  input  logic               req_fwh_i,
  input  logic [1:0]         req_size_i,
  input  logic [DATA_W-1:0]  req_wdata_i,
  output logic               host_wait_o,
  output logic               host_ack_o,
  output logic [DATA_W-1:0]  host_rdata_o,
  output logic               cmd_valid_o,
  input  logic               cmd_ready_i,
  output logic [7:0]         cmd_opcode_o,
  output logic [FADDR_W-1:0] cmd_addr_o,
  output logic [2:0]         cmd_count_o,
  output logic               cmd_dummy_o,
  output logic [DATA_W-1:0]  cmd_wdata_o,
  input  logic               eng_done_i,
  input  logic [DATA_W-1:0]  eng_rdata_i
);
  logic               hit, legal, dummy;
  logic [FADDR_W-1:0] faddr;
  logic [7:0]         opcode;
  logic [2:0]         count;
  cmd_desc_t          desc_d, desc_q;

  flash_win_decode #(.MIN_WIN_LOG2(MIN_WIN_LOG2)) u_decode (
    .base_i (cfg_base_i),
    .size_i (cfg_size_i),
    .addr_i (req_addr_i),
    .hit_o  (hit),
    .faddr_o(faddr)
  );

  flash_win_req_check u_check (
    .write_i  (req_write_i),
    .fwh_i    (req_fwh_i),
    .size_i   (req_size_i),
    .rd_fast_i(cfg_rd_fast_i),
    .wr_mode_i(cfg_wr_mode_i),
    .legal_o  (legal),
    .opcode_o (opcode),
    .dummy_o  (dummy),
    .count_o  (count)
  );

  always_comb begin
    desc_d.opcode = opcode;
    desc_d.addr   = faddr;
    desc_d.count  = count;
    desc_d.dummy  = dummy;
    desc_d.wdata  = req_wdata_i;
  end

  flash_win_ctrl u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .req_valid_i (req_valid_i),
    .accept_i    (hit && legal),
    .desc_i      (desc_d),
    .cmd_ready_i (cmd_ready_i),
    .eng_done_i  (eng_done_i),
    .eng_rdata_i (eng_rdata_i),
    .desc_o      (desc_q),
    .cmd_valid_o (cmd_valid_o),
    .host_wait_o (host_wait_o),
    .host_ack_o  (host_ack_o),
    .host_rdata_o(host_rdata_o)
  );

  assign cmd_opcode_o = desc_q.opcode;
  assign cmd_addr_o   = desc_q.addr;
  assign cmd_count_o  = desc_q.count;
  assign cmd_dummy_o  = desc_q.dummy;
  assign cmd_wdata_o  = desc_q.wdata;
endmodule

// File: rtl/flash_win_bridge_chk.sv
module flash_win_bridge_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        req_valid_i,
  input logic        host_wait_o,
  input logic        host_ack_o,
  input logic        cmd_valid_o,
  input logic        cmd_ready_i,
  input logic [7:0]  cmd_opcode_o,
  input logic [23:0] cmd_addr_o,
  input logic        eng_done_i
);
  p_ack_after_done_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    host_ack_o |-> $past(eng_done_i) && $past(host_wait_o));

  p_ack_pulse_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    host_ack_o |=> !host_ack_o);

  p_cmd_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_o && !cmd_ready_i |=> cmd_valid_o && $stable(cmd_addr_o) && $stable(cmd_opcode_o));

  p_cmd_in_wait_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_o |-> host_wait_o && !host_ack_o);

  p_opcode_set_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_o |-> (cmd_opcode_o == 8'h03 || cmd_opcode_o == 8'h0B ||
                     cmd_opcode_o == 8'h02 || cmd_opcode_o == 8'hAD));

  p_idle_quiet_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !host_wait_o && !host_ack_o && !req_valid_i |=> !cmd_valid_o && !host_wait_o);
endmodule

bind flash_win_bridge flash_win_bridge_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_valid_i (req_valid_i),
  .host_wait_o (host_wait_o),
  .host_ack_o  (host_ack_o),
  .cmd_valid_o (cmd_valid_o),
  .cmd_ready_i (cmd_ready_i),
  .cmd_opcode_o(cmd_opcode_o),
  .cmd_addr_o  (cmd_addr_o),
  .eng_done_i  (eng_done_i)
);

// File: tb/flash_win_bridge_tb.sv
module flash_win_bridge_tb;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [15:0] cfg_base_i = '0;
  logic [2:0]  cfg_size_i = '0;
  logic        cfg_rd_fast_i = 1'b0;
  logic [1:0]  cfg_wr_mode_i = '0;
  logic        req_valid_i = 1'b0;
  logic [31:0] req_addr_i = '0;
  logic        req_write_i = 1'b0;
  logic        req_fwh_i = 1'b0;
  logic [1:0]  req_size_i = '0;
  logic [31:0] req_wdata_i = '0;
  logic        host_wait_o, host_ack_o, cmd_valid_o, cmd_dummy_o;
  logic [31:0] host_rdata_o, cmd_wdata_o;
  logic        cmd_ready_i = 1'b0;
  logic [7:0]  cmd_opcode_o;
  logic [23:0] cmd_addr_o;
  logic [2:0]  cmd_count_o;
  logic        eng_done_i = 1'b0;
  logic [31:0] eng_rdata_i = '0;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #2 clk_i = ~clk_i;

  flash_win_bridge u_dut (.*);

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic bit exp_hit(input logic [31:0] a);
    longint unsigned st, sp;
    int c;
    c  = (cfg_size_i > 3'd4) ? 4 : int'(cfg_size_i);
    st = longint'(cfg_base_i) << 16;
    sp = 64'd1 << (20 + c);
    return (longint'(a) >= st) && (longint'(a) < st + sp);
  endfunction

  // one host transaction; stall = engine ready delay in cycles
  task automatic run(input logic [31:0] a, input bit wr, input bit fwh, input logic [1:0] sz,
                     input int stall, input bit poke_busy);
    bit legal, hit;
    logic [7:0] op;
    logic [31:0] wd, rd;
    legal = fwh ? (sz != 2'd3) : (sz == 2'd0);
    hit   = exp_hit(a) && legal;
    wd    = a ^ 32'h5A5A_0000;
    rd    = ~a;
    op    = wr ? ((cfg_wr_mode_i == 2'd2) ? 8'hAD : 8'h02) : (cfg_rd_fast_i ? 8'h0B : 8'h03);
    @(negedge clk_i);
    req_valid_i = 1'b1; req_addr_i = a; req_write_i = wr; req_fwh_i = fwh;
    req_size_i = sz; req_wdata_i = wd;
    @(negedge clk_i);
    req_valid_i = 1'b0;
    check(cmd_valid_o == hit, "R3/R6 cmd_valid", cmd_valid_o, hit);
    check(host_wait_o == hit, "R10 wait", host_wait_o, hit);
    if (!hit) begin
      for (int k = 0; k < 3; k++) begin
        @(negedge clk_i);
        check(!host_ack_o && !host_wait_o && !cmd_valid_o, "R5 miss quiet",
              {host_ack_o, host_wait_o, cmd_valid_o}, 0);
      end
      return;
    end
    check(cmd_addr_o == 24'(a - {cfg_base_i, 16'h0}), "R4 flash addr", cmd_addr_o, 24'(a - {cfg_base_i, 16'h0}));
    check(cmd_opcode_o == op, wr ? "R8 opcode" : "R7 opcode", cmd_opcode_o, op);
    check(cmd_dummy_o == (!wr && cfg_rd_fast_i), "R7 dummy", cmd_dummy_o, !wr && cfg_rd_fast_i);
    check(cmd_count_o == 3'(1 << sz), "R12 count", cmd_count_o, 3'(1 << sz));
    if (wr) check(cmd_wdata_o == wd, "R8 wdata", cmd_wdata_o, wd);
    for (int k = 0; k < stall; k++) begin
      if (poke_busy) begin req_valid_i = 1'b1; req_addr_i = a + 1; end
      @(negedge clk_i);
      req_valid_i = 1'b0;
      check(cmd_valid_o && cmd_addr_o == 24'(a - {cfg_base_i, 16'h0}), "R9 hold", cmd_valid_o, 1);
    end
    cmd_ready_i = 1'b1;
    @(negedge clk_i);
    cmd_ready_i = 1'b0;
    check(!cmd_valid_o && host_wait_o, "R10 wait after take", {cmd_valid_o, host_wait_o}, 1);
    if (poke_busy) begin req_valid_i = 1'b1; req_addr_i = a; end
    @(negedge clk_i);
    req_valid_i = 1'b0;
    check(host_wait_o && !host_ack_o, "R10 still waiting", {host_wait_o, host_ack_o}, 2);
    eng_done_i = 1'b1; eng_rdata_i = rd;
    if (poke_busy) begin req_valid_i = 1'b1; req_addr_i = a; end
    @(negedge clk_i);
    eng_done_i = 1'b0; req_valid_i = 1'b0;
    check(host_ack_o && !host_wait_o, "R10 ack", {host_ack_o, host_wait_o}, 2);
    check(host_rdata_o == rd, "R10 rdata", host_rdata_o, rd);
    if (poke_busy) begin req_valid_i = 1'b1; req_addr_i = a; end
    @(negedge clk_i);
    req_valid_i = 1'b0;
    check(!host_ack_o, "R10 ack one cycle", host_ack_o, 0);
    if (poke_busy) begin
      for (int k = 0; k < 3; k++) begin
        @(negedge clk_i);
        check(!cmd_valid_o && !host_wait_o && !host_ack_o, "R11 busy request ignored",
              {cmd_valid_o, host_wait_o, host_ack_o}, 0);
      end
    end
  endtask

  initial begin
    #(200000 * 4);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [15:0] bases [3] = '{16'h231F, 16'h0000, 16'hFFF8};
    repeat (2) @(negedge clk_i);
    check(!host_wait_o && !host_ack_o && !cmd_valid_o, "R1 in reset", {host_wait_o, host_ack_o, cmd_valid_o}, 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check(!host_wait_o && !host_ack_o && !cmd_valid_o, "R1 after reset", {host_wait_o, host_ack_o, cmd_valid_o}, 0);

    // R2 R3 R4: window sweep over every size code and several bases, edges of each window
    for (int b = 0; b < 3; b++) begin
      for (int c = 0; c < 8; c++) begin
        longint unsigned st, sp;
        cfg_base_i = bases[b]; cfg_size_i = 3'(c);
        st = longint'(bases[b]) << 16;
        sp = 64'd1 << (20 + ((c > 4) ? 4 : c));
        run(32'(st - 1), 1'b0, 1'b0, 2'd0, 0, 1'b0);
        run(32'(st), 1'b0, 1'b0, 2'd0, 0, 1'b0);
        run(32'(st + sp - 1), 1'b0, 1'b0, 2'd0, 0, 1'b0);
        run(32'(st + sp), 1'b0, 1'b0, 2'd0, 0, 1'b0);
      end
    end

    // R6 R7 R8 R12: cycle type x width x direction x mode
    cfg_base_i = 16'h231F; cfg_size_i = 3'd0;
    for (int m = 0; m < 4; m++) begin
      cfg_wr_mode_i = 2'(m); cfg_rd_fast_i = m[0];
      for (int f = 0; f < 2; f++)
        for (int s = 0; s < 4; s++)
          for (int w = 0; w < 2; w++)
            run(32'h2320_1234 + 32'(s), w[0], f[0], 2'(s), 0, 1'b0);
    end

    // R9 stall and R11 busy requests
    cfg_wr_mode_i = 2'd1; cfg_rd_fast_i = 1'b1;
    run(32'h2325_0000, 1'b1, 1'b1, 2'd2, 4, 1'b0);
    run(32'h231F_0010, 1'b0, 1'b1, 2'd1, 3, 1'b1);

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule